// File: doc/BRIEF.md
# Chainable PWM with staged configuration

A single-channel pulse-width modulator. A 16-bit up-counter advances once per prescaled tick, runs from zero to a programmed period and then starts over. The output is set when the count reaches an on-point and cleared when it reaches an off-point. All configuration writes go into a staged copy. That copy takes effect only when a hardware request on `trans_en_i` has been latched, and only at the counter's next restart. While the counter is stopped, the staged copy takes effect at once.

Several modules can be chained. Each start or restart emits a one-cycle `sync_o` pulse. When the staged copy was taken over at that restart, a matching `trans_en_o` pulse is emitted with it. Both pulses can be held back by a programmable number of clock cycles. Feeding one module's `sync_o` into the next module's `sync_i` restarts the downstream counter, and feeding `trans_en_o` into the next module's `trans_en_i` passes the update request down the chain.

Register select on `wr_addr_i`: 0 = control (bit 0 = run), 1 = period, 2 = prescale, 3 = sync delay, 4 = counter load value, 5 = on-point, 6 = off-point.

Top module: `sync_pwm`

## Requirements
- R1: While running, the counter advances by one every (prescale+1) clock cycles, wraps from the period value to 0, and so restarts every (period+1)*(prescale+1) cycles.
- R2: With on-point < off-point ≤ period, `pwm_o` is high for (off-point − on-point)*(prescale+1) cycles of each period. It rises one cycle after the count first equals the on-point and falls one cycle after the count first equals the off-point.
- R3: When the on-point equals the off-point, `pwm_o` stays low.
- R4: With run (control bit 0) cleared in the active settings, the counter holds, no sync pulse is emitted and `pwm_o` is low. Out of reset every output is 0.
- R5: A register write changes only the staged copy. Without a transfer request, the period, duty, count and pulses are unaffected.
- R6: A request on `trans_en_i` is latched and applied at the next restart, then cleared. When the counter is stopped, it is applied on the cycle after the request is latched.
- R7: Each start or restart emits a `sync_o` pulse one cycle long. With a delay of 0, it is visible in the first cycle of the new count (`cnt_o` = 0).
- R8: `trans_en_o` pulses in the same cycle as `sync_o`, and only for restarts at which the staged copy was applied.
- R9: With a sync delay of D (taken from the settings applied at that restart), both pulses appear D clock cycles after the restart. With no prescaling they coincide with `cnt_o` = D.
- R10: A `sync_i` pulse while running restarts the counter, so `cnt_o` is 0 in the next cycle.
- R11: When the staged copy is applied, the counter is loaded with the staged counter load value instead of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the staged copy |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | 16 | Write data |
| trans_en_i | input | 1 | Transfer request, staged to active |
| sync_i | input | 1 | Restart request from upstream |
| pwm_o | output | 1 | Modulated output |
| cnt_o | output | 16 | Current count |
| sync_o | output | 1 | Start/restart pulse, delayed |
| trans_en_o | output | 1 | Transfer-done pulse, aligned with sync_o |

## Verification
The properties assume that `sync_i` and `trans_en_i` are synchronous single-cycle pulses, and that any counter load value, on-point or off-point lies within the period. The checks on the delayed pulses also assume that the sync delay is shorter than the restart interval, so that a pending delayed pulse is never overtaken by a new restart. The stimulus keeps within these limits: it raises each request for exactly one cycle at a falling edge, uses delays smaller than the period, and writes a period first and then on-points and off-points below it.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_PERIOD = 3'd1,
    SEL_PSC    = 3'd2,
    SEL_DELAY  = 3'd3,
    SEL_COUNT  = 3'd4,
    SEL_ON     = 3'd5,
    SEL_OFF    = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/sync_pwm_regs.sv
module sync_pwm_regs
  import sync_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16,
  parameter int unsigned DLY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              trans_en_i,
  input  logic              restart_i,
  output logic              run_o,
  output logic              run_next_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [DLY_W-1:0]  dly_next_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  on_o,
  output logic [CNT_W-1:0]  off_o,
  output logic              apply_o
);
  logic             sh_run, run_q;
  logic [CNT_W-1:0] sh_prd, prd_q;
  logic [PSC_W-1:0] sh_psc, psc_q;
  logic [DLY_W-1:0] sh_dly, dly_q;
  logic [CNT_W-1:0] sh_cnt;
  logic [CNT_W-1:0] sh_on, on_q;
  logic [CNT_W-1:0] sh_off, off_q;
  logic             pend_q;

  // staged copy: written only by the bus side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_run <= 1'b0;
      sh_prd <= '0;
      sh_psc <= '0;
      sh_dly <= '0;
      sh_cnt <= '0;
      sh_on  <= '0;
      sh_off <= '0;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(wr_addr_i))
        SEL_CTRL:   sh_run <= wr_data_i[0];
        SEL_PERIOD: sh_prd <= wr_data_i;
        SEL_PSC:    sh_psc <= wr_data_i[PSC_W-1:0];
        SEL_DELAY:  sh_dly <= wr_data_i[DLY_W-1:0];
        SEL_COUNT:  sh_cnt <= wr_data_i;
        SEL_ON:     sh_on  <= wr_data_i;
        SEL_OFF:    sh_off <= wr_data_i;
        default:    ;
      endcase
    end
  end

  // a stopped counter takes the staged copy at once
  assign apply_o = pend_q && (restart_i || !run_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      prd_q  <= '0;
      psc_q  <= '0;
      dly_q  <= '0;
      on_q   <= '0;
      off_q  <= '0;
    end else begin
      if (trans_en_i)   pend_q <= 1'b1;
      else if (apply_o) pend_q <= 1'b0;
      if (apply_o) begin
        run_q <= sh_run;
        prd_q <= sh_prd;
        psc_q <= sh_psc;
        dly_q <= sh_dly;
        on_q  <= sh_on;
        off_q <= sh_off;
      end
    end
  end

  assign run_o      = run_q;
  assign run_next_o = apply_o ? sh_run : run_q;
  assign period_o   = prd_q;
  assign psc_o      = psc_q;
  assign dly_next_o = apply_o ? sh_dly : dly_q;
  assign load_o     = sh_cnt;
  assign on_o       = on_q;
  assign off_o      = off_q;

  p_pend_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_o && !trans_en_i) |=> !pend_q);
  p_active_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_o |=> $stable({run_q, prd_q, psc_q, dly_q, on_q, off_q}));
endmodule

// File: rtl/sync_pwm_timebase.sv
module sync_pwm_timebase #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] on_i,
  input  logic [CNT_W-1:0] off_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             apply_i,
  input  logic             sync_i,
  output logic             restart_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PSC_W-1:0] psc_q;
  logic             pwm_q;
  logic             tick;

  assign tick      = (psc_q == psc_i);
  assign restart_o = run_i && ((tick && cnt_q == period_i) || sync_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      psc_q <= '0;
    end else if (restart_o || apply_i) begin
      cnt_q <= apply_i ? load_i : '0;
      psc_q <= '0;
    end else if (run_i) begin
      if (tick) begin
        cnt_q <= cnt_q + 1'b1;
        psc_q <= '0;
      end else begin
        psc_q <= psc_q + 1'b1;
      end
    end
  end

  // output level tracks the count one cycle behind
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pwm_q <= 1'b0;
    else if (!run_i)             pwm_q <= 1'b0;
    else if (on_i == off_i)      pwm_q <= 1'b0;
    else if (cnt_q == on_i)      pwm_q <= 1'b1;
    else if (cnt_q == off_i)     pwm_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign pwm_o = pwm_q;

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && cnt_q == period_i && !apply_i) |=> cnt_q == '0);
  p_stop_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !pwm_o);
  p_equal_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && on_i == off_i) |=> !pwm_o);
  p_sync_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && run_i && !apply_i) |=> cnt_q == '0);
endmodule

// File: rtl/sync_pwm_delay.sv
module sync_pwm_delay #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             xfer_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             sync_o,
  output logic             xfer_o
);
  logic [DLY_W-1:0] dcnt_q;
  logic             armed_q, xpend_q, sync_q, xfer_q;

  // a new event drops any pulse still waiting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q  <= '0;
      armed_q <= 1'b0;
      xpend_q <= 1'b0;
      sync_q  <= 1'b0;
      xfer_q  <= 1'b0;
    end else if (event_i) begin
      if (dly_i == '0) begin
        sync_q  <= 1'b1;
        xfer_q  <= xfer_i;
        armed_q <= 1'b0;
      end else begin
        sync_q  <= 1'b0;
        xfer_q  <= 1'b0;
        dcnt_q  <= dly_i;
        xpend_q <= xfer_i;
        armed_q <= 1'b1;
      end
    end else if (armed_q && dcnt_q == 1) begin
      sync_q  <= 1'b1;
      xfer_q  <= xpend_q;
      armed_q <= 1'b0;
    end else begin
      sync_q <= 1'b0;
      xfer_q <= 1'b0;
      if (armed_q) dcnt_q <= dcnt_q - 1'b1;
    end
  end

  assign sync_o = sync_q;
  assign xfer_o = xfer_q;

  p_xfer_with_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> sync_o);
  p_zero_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && dly_i == '0) |=> sync_o);
  p_delay_fire_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && dcnt_q == 1 && !event_i) |=> sync_o);
endmodule

// File: rtl/sync_pwm.sv
module sync_pwm
  import sync_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16,
  parameter int unsigned DLY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              trans_en_i,
  input  logic              sync_i,
  output logic              pwm_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              sync_o,
  output logic              trans_en_o
);
  logic             run, run_next, apply, restart, start_evt;
  logic [CNT_W-1:0] period, load, on_pt, off_pt;
  logic [PSC_W-1:0] psc;
  logic [DLY_W-1:0] dly_next;

  sync_pwm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DLY_W(DLY_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .trans_en_i,
    .restart_i(restart), .run_o(run), .run_next_o(run_next),
    .period_o(period), .psc_o(psc), .dly_next_o(dly_next), .load_o(load),
    .on_o(on_pt), .off_o(off_pt), .apply_o(apply)
  );

  sync_pwm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk_i, .rst_ni, .run_i(run), .period_i(period), .psc_i(psc),
    .on_i(on_pt), .off_i(off_pt), .load_i(load), .apply_i(apply),
    .sync_i, .restart_o(restart), .cnt_o, .pwm_o
  );

  // first start out of the stopped state counts as a start
  assign start_evt = apply && !run && run_next;

  sync_pwm_delay #(.DLY_W(DLY_W)) u_dly (
    .clk_i, .rst_ni, .event_i(restart || start_evt), .xfer_i(apply),
    .dly_i(dly_next), .sync_o, .xfer_o(trans_en_o)
  );
endmodule

// File: tb/sync_pwm_bench.sv
module sync_pwm_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trans_en = 1'b0;
  logic        sync_in = 1'b0;
  logic        pwm, sync_out, xfer_out;
  logic [15:0] cnt;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  sync_pwm u_sync_pwm (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .trans_en_i(trans_en), .sync_i(sync_in),
    .pwm_o(pwm), .cnt_o(cnt), .sync_o(sync_out), .trans_en_o(xfer_out)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic wr(int addr, int data);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stage(int run, int prd, int psc, int dly, int ld, int on_p, int off_p);
    wr(0, run); wr(1, prd); wr(2, psc); wr(3, dly); wr(4, ld); wr(5, on_p); wr(6, off_p);
  endtask

  task automatic wait_sync(string req);
    int n = 0;
    while (!sync_out && n < 2000) begin @(negedge clk); n++; end
    if (!sync_out) chk(req, 0, 1);
  endtask

  // request transfer, wait for the transfer-done pulse
  task automatic do_xfer(string req);
    int n = 0;
    trans_en = 1'b1; @(negedge clk); trans_en = 1'b0;
    while (!xfer_out && n < 2000) begin @(negedge clk); n++; end
    chk(req, int'(xfer_out), 1);
    chk(req, int'(sync_out), 1);
  endtask

  task automatic measure(string req, output int spacing, output int high);
    wait_sync(req);
    spacing = 0; high = 0;
    do begin
      high += int'(pwm); spacing++;
      @(negedge clk);
    end while (!sync_out && spacing < 2000);
  endtask

  task automatic t_reset();
    chk("R4 reset sync", int'(sync_out), 0);
    chk("R4 reset xfer", int'(xfer_out), 0);
    chk("R4 reset pwm", int'(pwm), 0);
    chk("R4 reset cnt", int'(cnt), 0);
  endtask

  task automatic t_staged_only();
    int seen = 0;
    stage(1, 9, 0, 0, 0, 2, 6);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      seen += int'(sync_out) + int'(pwm) + int'(cnt != 0);
    end
    chk("R5 writes alone inert", seen, 0);
  endtask

  task automatic t_start_stopped();
    trans_en = 1'b1; @(negedge clk); trans_en = 1'b0;
    chk("R6 not yet applied", int'(sync_out), 0);
    @(negedge clk);
    chk("R6 start sync", int'(sync_out), 1);
    chk("R8 start xfer", int'(xfer_out), 1);
    chk("R7 count zero at sync", int'(cnt), 0);
    @(negedge clk);
    chk("R7 one cycle pulse", int'(sync_out), 0);
  endtask

  task automatic t_period_duty();
    int sp, hi;
    measure("R1 period", sp, hi);
    chk("R1 spacing", sp, 10);
    chk("R2 high", hi, 4);
    chk("R8 no xfer without update", int'(xfer_out), 0);
    chk("R7 delay0 cnt", int'(cnt), 0);
  endtask

  task automatic t_ignore_running();
    int sp, hi;
    wr(1, 19);
    measure("R5 running", sp, hi);
    measure("R5 running", sp, hi);
    chk("R5 period kept", sp, 10);
    wr(1, 9);
  endtask

  task automatic t_prescale();
    int sp, hi;
    stage(1, 4, 2, 0, 0, 1, 3);
    do_xfer("R6 prescale apply");
    measure("R1 prescale", sp, hi);
    chk("R1 prescaled spacing", sp, 15);
    chk("R2 prescaled high", hi, 6);
  endtask

  task automatic t_equal();
    int sp, hi;
    stage(1, 9, 0, 0, 0, 3, 3);
    do_xfer("R3 apply");
    measure("R3", sp, hi);
    measure("R3", sp, hi);
    chk("R3 equal points low", hi, 0);
  endtask

  task automatic t_delay();
    int sp, hi;
    stage(1, 9, 0, 3, 0, 2, 6);
    do_xfer("R9 apply");
    chk("R9 xfer delayed", int'(cnt), 3);
    measure("R9", sp, hi);
    chk("R9 sync delayed", int'(cnt), 3);
    chk("R9 spacing kept", sp, 10);
    stage(1, 9, 0, 0, 0, 2, 6);
    do_xfer("R9 restore");
    chk("R9 new delay used", int'(cnt), 0);
  endtask

  task automatic t_sync_in();
    int n = 0;
    while (cnt != 4 && n < 100) begin @(negedge clk); n++; end
    sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
    chk("R10 count restarted", int'(cnt), 0);
    chk("R10 sync out", int'(sync_out), 1);
    @(negedge clk);
    chk("R10 counting on", int'(cnt), 1);
  endtask

  task automatic t_load();
    int sp, hi;
    stage(1, 9, 0, 0, 5, 2, 6);
    do_xfer("R11 apply");
    chk("R11 loaded count", int'(cnt), 5);
    @(negedge clk);
    sp = 1;
    while (!sync_out && sp < 100) begin @(negedge clk); sp++; end
    chk("R11 shortened first period", sp, 5);
    stage(1, 9, 0, 0, 0, 2, 6);
    do_xfer("R11 restore");
    chk("R11 zero load", int'(cnt), 0);
  endtask

  task automatic t_stop();
    int held, seen;
    stage(0, 9, 0, 0, 0, 2, 6);
    do_xfer("R4 apply stop");
    @(negedge clk); @(negedge clk);
    held = int'(cnt); seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      seen += int'(sync_out) + int'(pwm) + int'(int'(cnt) != held);
    end
    chk("R4 stopped inert", seen, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_staged_only();
    t_start_stopped();
    t_period_duty();
    t_ignore_running();
    t_prescale();
    t_equal();
    t_delay();
    t_sync_in();
    t_load();
    t_stop();
    finish_run();
  end
endmodule